// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. A burst opens when either of two independent address strobes is sampled high on a rising clock edge. One strobe belongs to the processor and the other to a cache controller. On that edge the block captures the full incoming address and the burst order. After that, each clock edge with the advance input high moves the burst to its next beat. Only the low two address bits change. The upper bits stay at their captured value.

Two burst orders are available. In the interleaved order the low bits are the captured start bits XORed with the beat count. In the linear order they are the start bits plus the beat count, wrapping modulo four. A flag marks the fourth beat. The counter wraps after that beat and repeats the same sequence until a new strobe arrives.

A small state machine has two named states. `ST_IDLE` means no burst has been captured since reset. `ST_BURST` means a burst address is held. Transition `IDLE->BURST` fires on any strobe. `BURST->BURST` is taken on every later edge, either reloading on a strobe or stepping or holding on advance. Only reset returns the machine to `ST_IDLE`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset and until the first strobe, `addr_o` is all zeros and `final_beat_o` is low; `advance_i` in this period has no effect.
- R2: A high level on `proc_strobe_i` or on `ctrl_strobe_i` at a rising edge loads `addr_i`. From the next cycle `addr_o` equals that address, which is beat 0.
- R3: With no strobe, each rising edge with `advance_i` high moves to the next beat. With `advance_i` low, `addr_o` holds.
- R4: With `order_sel_i` = 0 (interleaved) captured, `addr_o[1:0]` equals start bits XOR beat count. For example, a start of 1 gives 1,0,3,2.
- R5: With `order_sel_i` = 1 (linear) captured, `addr_o[1:0]` equals (start bits + beat count) mod 4. For example, a start of 1 gives 1,2,3,0.
- R6: `order_sel_i` is sampled only on a strobe edge. Changing it during a burst does not alter the sequence.
- R7: When a strobe and `advance_i` are high on the same edge, the load wins and the burst restarts at beat 0 with the new address.
- R8: Advancing from beat 3 returns to beat 0, and the sequence repeats from the captured start address.
- R9: `final_beat_o` is high exactly while a burst is at beat 3.
- R10: `addr_o[ADDR_W-1:2]` equals the upper bits captured at the last strobe for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe_i | input | 1 | Processor address strobe, starts a burst |
| ctrl_strobe_i | input | 1 | Controller address strobe, starts a burst |
| advance_i | input | 1 | Step to the next beat |
| order_sel_i | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr_i | input | ADDR_W | Start address of a burst |
| addr_o | output | ADDR_W | Current beat address |
| final_beat_o | output | 1 | High on the fourth beat |

## Verification
The assertions assume that every input is a known 0 or 1 on each sampled edge. They also assume that `addr_i` and `order_sel_i` matter only on edges where a strobe is high. No property depends on how long the strobes or `advance_i` stay high. The bench changes inputs only on falling clock edges, so every input is settled before the next rising edge. Between strobes it deliberately drives `addr_i` and `order_sel_i` to unrelated values, so the properties that depend on capture are exercised against changing inputs.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);

    burst_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = load_i ? ST_BURST : ST_IDLE;
            ST_BURST: state_d = ST_BURST;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        active_o = (state_q == ST_BURST);
    end

    p_idle_until_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !load_i) |=> !active_o);
    p_enter_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> active_o);

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};
    localparam logic [BEAT_W-1:0] ONE_BEAT  = {{(BEAT_W-1){1'b0}}, 1'b1};

    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (load_i) beat_q <= '0;
        else if (step_i) beat_q <= beat_q + ONE_BEAT;
    end

    always_comb begin
        beat_o = beat_q;
        last_o = (beat_q == LAST_BEAT);
    end

    p_step_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && beat_q != LAST_BEAT) |=> beat_q == $past(beat_q) + ONE_BEAT);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(beat_q));
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && beat_q == LAST_BEAT) |=> beat_q == '0);
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_q == '0);

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              active_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    burst_order_e      order_q;
    logic [BEAT_W-1:0] low_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load_i) begin
            upper_q <= addr_i[ADDR_W-1:BEAT_W];
            start_q <= addr_i[BEAT_W-1:0];
            order_q <= burst_order_e'(order_i);
        end
    end

    always_comb begin
        unique case (order_q)
            ORD_LINEAR:     low_d = start_q + beat_i;
            ORD_INTERLEAVE: low_d = start_q ^ beat_i;
            default:        low_d = start_q;
        endcase
        addr_o = active_i ? {upper_q, low_d} : '0;
    end

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(order_q) && $stable(start_q)));
    p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !load_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe_i,
    input  logic              ctrl_strobe_i,
    input  logic              advance_i,
    input  logic              order_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              final_beat_o
);

    logic              load;
    logic              step;
    logic              active;
    logic [BEAT_W-1:0] beat;
    logic              last;

    // either strobe opens a burst; load outranks advance
    assign load = proc_strobe_i | ctrl_strobe_i;
    assign step = advance_i & active & ~load;

    burst_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .active_o (active)
    );

    burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .beat_o (beat),
        .last_o (last)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .order_i  (order_sel_i),
        .addr_i   (addr_i),
        .active_i (active),
        .beat_i   (beat),
        .addr_o   (addr_o)
    );

    assign final_beat_o = active & last;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (addr_o == '0 && !final_beat_o));
    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_o == $past(addr_i) && !final_beat_o));
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && advance_i) |=> addr_o == $past(addr_i));
    p_final_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (final_beat_o && advance_i && !load) |=> !final_beat_o);

endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              proc_strobe_i = 1'b0;
    logic              ctrl_strobe_i = 1'b0;
    logic              advance_i = 1'b0;
    logic              order_sel_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              final_beat_o;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .proc_strobe_i (proc_strobe_i),
        .ctrl_strobe_i (ctrl_strobe_i),
        .advance_i     (advance_i),
        .order_sel_i   (order_sel_i),
        .addr_i        (addr_i),
        .addr_o        (addr_o),
        .final_beat_o  (final_beat_o)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              fin;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // reference model state
    logic              m_active = 1'b0;
    logic [ADDR_W-3:0] m_upper  = '0;
    logic [1:0]        m_start  = '0;
    logic [1:0]        m_beat   = '0;
    logic              m_lin    = 1'b0;

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [1:0] lo;
        lo = m_lin ? 2'(m_start + m_beat) : (m_start ^ m_beat);
        return m_active ? {m_upper, lo} : '0;
    endfunction

    task automatic drive(input logic ps, input logic cs, input logic adv,
                         input logic ord, input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        proc_strobe_i = ps;
        ctrl_strobe_i = cs;
        advance_i     = adv;
        order_sel_i   = ord;
        addr_i        = a;
        if (ps || cs) begin
            m_active = 1'b1;
            m_upper  = a[ADDR_W-1:2];
            m_start  = a[1:0];
            m_lin    = ord;
            m_beat   = 2'd0;
        end else if (adv && m_active) begin
            m_beat = 2'(m_beat + 2'd1);
        end
        e.addr = model_addr();
        e.fin  = m_active && (m_beat == 2'd3);
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (addr_o !== e.addr || final_beat_o !== e.fin) begin
                    n_fail++;
                    $display("FAIL %s: addr_o=%h final=%b expected addr=%h final=%b",
                             e.tag, addr_o, final_beat_o, e.addr, e.fin);
                end
            end
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (addr_o !== '0 || final_beat_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: addr_o=%h final=%b expected 0 0", addr_o, final_beat_o);
        end
        // R1: advance before any strobe is ignored
        drive(0, 0, 1, 0, 18'h3ffff, "R1 idle advance");
        drive(0, 0, 1, 1, 18'h12345, "R1 idle advance");

        // R4 R5 R8 R9 R10: every start offset, both orders, run past the wrap
        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 4; s++) begin
                logic [ADDR_W-1:0] a;
                a = {16'h5a00 + 16'(s * 37 + ord * 11), 2'(s)};
                drive(ord == 0, ord == 1, 0, 1'(ord), a, "R2 load");
                for (int k = 0; k < 6; k++)
                    drive(0, 0, 1, 1'(~ord), ~a,
                          ord == 0 ? "R4 R8 R9 R10 interleaved" : "R5 R8 R9 R10 linear");
            end
        end

        // R3: hold without advance, then step
        drive(1, 0, 0, 1, 18'h00402, "R2 load");
        drive(0, 0, 1, 1, 18'h0, "R3 step");
        drive(0, 0, 0, 0, 18'h3fffd, "R3 hold");
        drive(0, 0, 0, 0, 18'h11111, "R3 hold");
        drive(0, 0, 1, 0, 18'h0, "R3 step");

        // R6: order input toggled mid burst has no effect
        drive(0, 1, 0, 0, 18'h2a6c3, "R2 ctrl load");
        drive(0, 0, 1, 1, 18'h0, "R6 order change ignored");
        drive(0, 0, 1, 1, 18'h0, "R6 order change ignored");
        drive(0, 0, 1, 0, 18'h0, "R6 order change ignored");

        // R7: strobe with advance restarts at beat 0
        drive(0, 0, 1, 0, 18'h0, "R9 step");
        drive(1, 0, 1, 1, 18'h1c001, "R7 load beats advance");
        drive(0, 0, 1, 1, 18'h0, "R7 after restart");
        drive(0, 1, 1, 0, 18'h0bbb3, "R7 load beats advance");
        drive(1, 1, 1, 1, 18'h03332, "R7 both strobes");
        drive(0, 0, 1, 0, 18'h0, "R5 linear step");

        @(negedge clk);
        proc_strobe_i = 0; ctrl_strobe_i = 0; advance_i = 0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule